// File: doc/BRIEF.md
# End-of-Interrupt Frame Serial Transmitter

This block announces the completion of a level-triggered interrupt on a two-wire serial interrupt bus. It sends one 2-bit symbol per bus clock. A single-cycle start request, together with a 4-bit arbitration identifier and an 8-bit vector, launches a fixed 14-symbol frame. The frame contains a header marking it as an end-of-interrupt notice, the identifier bit by bit, the vector in 2-bit pairs, a folded checksum over the vector pairs, a gap, two status slots and a trailing idle slot.

In the status slots the transmitter stops driving the bus and samples it. When the first status slot shows both wires high, another agent has rejected the frame. The transmitter then raises a one-cycle retry flag and sends the same frame again, starting with the header. A frame that ends without such a rejection ends with a one-cycle done pulse, and the block becomes idle in that same cycle. The block does not arbitrate between senders or model the bus electrically.

Top module: `eoi_frame_tx`

## Requirements
- R1: While and after reset, `busy_o`, `done_o` and `retry_o` are 0 and `bus_tx_o` is 00.
- R2: A `start_i` seen at a clock edge while idle begins a frame. In the following cycle `busy_o` is 1 and `bus_tx_o` carries the header symbol 11. Symbol k of the frame (k = 1..14) appears k cycles after the accepting edge.
- R3: Symbols 2, 3, 4 and 5 put identifier bits 3, 2, 1 and 0, in that order, on bit 1 of `bus_tx_o`, with bit 0 at 0.
- R4: Symbols 6 to 9 carry the vector as bit pairs [7:6], [5:4], [3:2], [1:0], in that order.
- R5: Symbol 10 is the checksum. It starts from 0 and adds the four vector pairs in order as 2-bit values. The carry out of each of the first three additions is added back into the sum, and the carry of the fourth addition is discarded.
- R6: Symbols 11 to 14 (gap, both status slots, idle) drive 00.
- R7: If `bus_rx_i` is 11 in symbol 12, then in the cycle after symbol 14 `retry_o` is 1 for one cycle, `busy_o` stays 1, `done_o` stays 0, and the frame restarts at symbol 1 with the originally captured identifier and vector.
- R8: If `bus_rx_i` is anything other than 11 in symbol 12, then in the cycle after symbol 14 `done_o` is 1 for one cycle, `retry_o` is 0 and `busy_o` is 0. The value of `bus_rx_i` in every other symbol has no effect.
- R9: A `start_i`, identifier or vector presented while busy has no effect on the current frame's symbols and starts no extra frame.
- R10: While idle, `bus_tx_o` is 00.
- R11: A start presented in the cycle where `done_o` is high is accepted, so frames can follow back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to send one frame |
| arb_id_i | input | 4 | Arbitration identifier, captured on start |
| vector_i | input | 8 | Interrupt vector, captured on start |
| bus_rx_i | input | 2 | Bus level observed by the transmitter |
| bus_tx_o | output | 2 | Symbol driven onto the bus |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse: frame finished without rejection |
| retry_o | output | 1 | One-cycle pulse: frame rejected and being resent |

## Verification
A symbol counter that is off by one shows at `bus_tx_o` as a shifted identifier or vector within five cycles of the start. If the counter drifts later in the frame, the handshake pulse appears one cycle early or late. A wrong checksum fold shows only on symbol 10, and only for vectors whose pairs produce carries, so all-ones and mixed vectors are driven. A status sample taken in the wrong slot leaves `retry_o` and `done_o` swapped three cycles later. A capture register that is not protected while busy corrupts the resent frame, which is why rejected frames are followed symbol by symbol.

// File: rtl/eoi_tx_pkg.sv
package eoi_tx_pkg;

   // Slot layout: header, id bits, vector pairs, checksum, gap, two status, idle
   function automatic int frame_len(input int id_w, input int vec_w, input int sym_w);
      return 1 + id_w + (vec_w / sym_w) + 5;
   endfunction

   function automatic int cksum_slot(input int id_w, input int vec_w, input int sym_w);
      return 1 + id_w + (vec_w / sym_w);
   endfunction

   function automatic int status_slot(input int id_w, input int vec_w, input int sym_w);
      return cksum_slot(id_w, vec_w, sym_w) + 2;
   endfunction

endpackage

// File: rtl/eoi_cksum.sv
module eoi_cksum #(
   parameter int VEC_W   = 8,
   parameter int SYM_W   = 2,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [VEC_W-1:0] vec,
   output logic [SYM_W-1:0] ck
);
   localparam int NSYM = VEC_W / SYM_W;

   logic [SYM_W-1:0] acc [NSYM+1];
   assign acc[0] = '0;

   for (genvar i = 0; i < NSYM; i++) begin : g_fold
      logic [SYM_W:0] part;
      assign part = {1'b0, acc[i]} + {1'b0, vec[VEC_W-1-i*SYM_W -: SYM_W]};
      if (i < NSYM - 1) begin : g_wrap
         assign acc[i+1] = part[SYM_W-1:0] + {{(SYM_W-1){1'b0}}, part[SYM_W]};
      end else begin : g_drop
         assign acc[i+1] = part[SYM_W-1:0];
      end
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    ck <= '0;
         else if (load) ck <= acc[NSYM];
      end
   end else begin : g_comb
      assign ck = acc[NSYM];
   end

endmodule

// File: rtl/eoi_seq.sv
module eoi_seq #(
   parameter int LEN      = 14,
   parameter int ST_IDX   = 11,
   parameter int SYM_W    = 2,
   localparam int CNT_W   = $clog2(LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [SYM_W-1:0] bus_rx,
   output logic             accept,
   output logic             busy,
   output logic [CNT_W-1:0] cnt,
   output logic             done,
   output logic             retry
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LEN - 1);
   localparam logic [CNT_W-1:0] STAT = CNT_W'(ST_IDX);

   logic rejected;

   assign accept = start && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         cnt      <= '0;
         done     <= 1'b0;
         retry    <= 1'b0;
         rejected <= 1'b0;
      end else begin
         done  <= 1'b0;
         retry <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy     <= 1'b1;
               cnt      <= '0;
               rejected <= 1'b0;
            end
         end else if (cnt == LAST) begin
            cnt      <= '0;
            rejected <= 1'b0;
            if (rejected) begin
               retry <= 1'b1;
            end else begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end else begin
            if (cnt == STAT && bus_rx == '1) rejected <= 1'b1;
            cnt <= cnt + CNT_W'(1);
         end
      end
   end

   // R2: a frame in progress advances one slot per cycle until its last slot
   a_r2_slot_advance: assert property (@(posedge clk) disable iff (!rst_n)
      busy && cnt != LAST |=> busy && cnt == $past(cnt) + CNT_W'(1));

   // R7: a resend starts from the header slot and keeps the block busy
   a_r7_retry_restart: assert property (@(posedge clk) disable iff (!rst_n)
      retry |-> busy && cnt == '0 && !done);

   // R8: completion leaves the block idle
   a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && !retry);

   // R8: completion only follows the last slot of a frame
   a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      busy && cnt == LAST |=> $countones({done, retry}) == 1);

endmodule

// File: rtl/eoi_sym_mux.sv
module eoi_sym_mux #(
   parameter int ID_W   = 4,
   parameter int VEC_W  = 8,
   parameter int SYM_W  = 2,
   parameter int CNT_W  = 4,
   parameter int CK_IDX = 9
) (
   input  logic             busy,
   input  logic [CNT_W-1:0] cnt,
   input  logic [ID_W-1:0]  id,
   input  logic [VEC_W-1:0] vec,
   input  logic [SYM_W-1:0] ck,
   output logic [SYM_W-1:0] sym
);
   localparam int NSYM = VEC_W / SYM_W;

   always_comb begin
      sym = '0;
      if (busy) begin
         if (cnt == '0) sym = '1;
         for (int i = 0; i < ID_W; i++) begin
            if (cnt == CNT_W'(1 + i)) sym = {id[ID_W-1-i], {(SYM_W-1){1'b0}}};
         end
         for (int j = 0; j < NSYM; j++) begin
            if (cnt == CNT_W'(1 + ID_W + j)) sym = vec[VEC_W-1-j*SYM_W -: SYM_W];
         end
         if (cnt == CNT_W'(CK_IDX)) sym = ck;
      end
   end

endmodule

// File: rtl/eoi_frame_tx.sv
module eoi_frame_tx #(
   parameter int ID_W      = 4,
   parameter int VEC_W     = 8,
   parameter int SYM_W     = 2,
   parameter bit CKSUM_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [ID_W-1:0]  arb_id_i,
   input  logic [VEC_W-1:0] vector_i,
   input  logic [SYM_W-1:0] bus_rx_i,
   output logic [SYM_W-1:0] bus_tx_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             retry_o
);
   import eoi_tx_pkg::*;

   localparam int LEN    = frame_len(ID_W, VEC_W, SYM_W);
   localparam int CK_IDX = cksum_slot(ID_W, VEC_W, SYM_W);
   localparam int ST_IDX = status_slot(ID_W, VEC_W, SYM_W);
   localparam int CNT_W  = $clog2(LEN);

   if (SYM_W < 2) begin : g_bad_sym
      $error("SYM_W must be at least 2");
   end
   if (VEC_W % SYM_W != 0) begin : g_bad_vec
      $error("VEC_W must be a multiple of SYM_W");
   end
   if (ID_W < 1) begin : g_bad_id
      $error("ID_W must be at least 1");
   end

   logic             accept;
   logic [CNT_W-1:0] cnt;
   logic [ID_W-1:0]  id_q;
   logic [VEC_W-1:0] vec_q;
   logic [SYM_W-1:0] ck;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         id_q  <= '0;
         vec_q <= '0;
      end else if (accept) begin
         id_q  <= arb_id_i;
         vec_q <= vector_i;
      end
   end

   eoi_seq #(.LEN(LEN), .ST_IDX(ST_IDX), .SYM_W(SYM_W)) i_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start_i),
      .bus_rx (bus_rx_i),
      .accept (accept),
      .busy   (busy_o),
      .cnt    (cnt),
      .done   (done_o),
      .retry  (retry_o)
   );

   eoi_cksum #(.VEC_W(VEC_W), .SYM_W(SYM_W), .REG_OUT(CKSUM_REG)) i_cksum (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept),
      .vec   (CKSUM_REG ? vector_i : vec_q),
      .ck    (ck)
   );

   eoi_sym_mux #(.ID_W(ID_W), .VEC_W(VEC_W), .SYM_W(SYM_W), .CNT_W(CNT_W),
                 .CK_IDX(CK_IDX)) i_mux (
      .busy (busy_o),
      .cnt  (cnt),
      .id   (id_q),
      .vec  (vec_q),
      .ck   (ck),
      .sym  (bus_tx_o)
   );

   // R10: an idle transmitter leaves the bus released
   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> bus_tx_o == '0);

   // R2: the first slot after acceptance is the all-ones header
   a_r2_header: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> busy_o && bus_tx_o == '1);

   // R6: gap, status and idle slots never drive the bus
   a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && cnt > CNT_W'(CK_IDX) |-> bus_tx_o == '0);

   // R9: captured frame contents cannot change during a frame
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> $stable(id_q) && $stable(vec_q));

endmodule

// File: tb/test_eoi_frame_tx.sv
`timescale 1ns/1ps
module test_eoi_frame_tx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [3:0] arb_id_i = '0;
   logic [7:0] vector_i = '0;
   logic [1:0] bus_rx_i = '0;
   logic [1:0] bus_tx_o;
   logic       busy_o, done_o, retry_o;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   eoi_frame_tx i_eoi_frame_tx (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .arb_id_i(arb_id_i),
      .vector_i(vector_i), .bus_rx_i(bus_rx_i), .bus_tx_o(bus_tx_o),
      .busy_o(busy_o), .done_o(done_o), .retry_o(retry_o)
   );

   function automatic logic [1:0] exp_ck(input logic [7:0] v);
      logic [1:0] s = 2'b00;
      for (int i = 0; i < 4; i++) begin
         logic [2:0] t;
         t = {1'b0, s} + {1'b0, v[7-2*i -: 2]};
         s = (i < 3) ? t[1:0] + {1'b0, t[2]} : t[1:0];
      end
      return s;
   endfunction

   function automatic logic [1:0] exp_sym(input int k, input logic [3:0] id, input logic [7:0] v);
      if (k == 1) return 2'b11;
      if (k >= 2 && k <= 5) return {id[5-k], 1'b0};
      if (k >= 6 && k <= 9) return v[(9-k)*2 +: 2];
      if (k == 10) return exp_ck(v);
      return 2'b00;
   endfunction

   function automatic string req_of(input int k);
      if (k == 1) return "R2";
      if (k <= 5) return "R3";
      if (k <= 9) return "R4";
      if (k == 10) return "R5";
      return "R6";
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // Called at a falling edge; returns at the falling edge after the last symbol
   task automatic send_frame(input logic [3:0] id, input logic [7:0] v,
                             input int n_rej, input int poke_at);
      int rej_left = n_rej;
      start_i = 1'b1; arb_id_i = id; vector_i = v;
      @(negedge clk);
      start_i = 1'b0; arb_id_i = 4'($urandom); vector_i = 8'($urandom);
      forever begin
         for (int k = 1; k <= 14; k++) begin
            chk(bus_tx_o == exp_sym(k, id, v), req_of(k), bus_tx_o, exp_sym(k, id, v));
            if (k == 7) chk(busy_o == 1'b1, "R2", busy_o, 1);
            if (k == poke_at) begin   // R9: ignored start while busy
               start_i = 1'b1; arb_id_i = ~id; vector_i = ~v;
            end else begin
               start_i = 1'b0;
            end
            if (k == 12) bus_rx_i = (rej_left > 0) ? 2'b11 : 2'($urandom % 3);
            else bus_rx_i = 2'($urandom);   // R8: ignored outside symbol 12
            @(negedge clk);
         end
         start_i = 1'b0; bus_rx_i = 2'b00;
         if (rej_left > 0) begin
            rej_left--;
            chk(retry_o == 1'b1, "R7", retry_o, 1);
            chk(done_o == 1'b0, "R7", done_o, 0);
            chk(busy_o == 1'b1, "R7", busy_o, 1);
         end else begin
            chk(done_o == 1'b1, "R8", done_o, 1);
            chk(retry_o == 1'b0, "R8", retry_o, 0);
            chk(busy_o == 1'b0, "R8", busy_o, 0);
            break;
         end
      end
   endtask

   task automatic idle_cycles(input int n);
      for (int i = 0; i < n; i++) begin
         bus_rx_i = 2'($urandom);
         @(negedge clk);
         chk(bus_tx_o == 2'b00, "R10", bus_tx_o, 0);
         chk(busy_o == 1'b0 && done_o == 1'b0, "R9", {busy_o, done_o}, 0);
      end
      bus_rx_i = 2'b00;
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++; n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'h5eed_0e01));
      repeat (3) @(negedge clk);
      chk(busy_o == 0 && done_o == 0 && retry_o == 0 && bus_tx_o == 0, "R1",
          {busy_o, done_o, retry_o, bus_tx_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy_o == 0 && done_o == 0 && retry_o == 0 && bus_tx_o == 0, "R1",
          {busy_o, done_o, retry_o, bus_tx_o}, 0);
      idle_cycles(4);

      // Directed corners: zero checksum, all-carry vector, rejections, back-to-back (R11)
      send_frame(4'h0, 8'h00, 0, 0);
      send_frame(4'hF, 8'hFF, 0, 3);
      send_frame(4'hA, 8'h5A, 1, 14);
      send_frame(4'h5, 8'hC3, 2, 9);
      idle_cycles(3);
      send_frame(4'h9, 8'hEE, 0, 12);
      idle_cycles(2);

      for (int f = 0; f < 60; f++) begin
         send_frame(4'($urandom), 8'($urandom), ($urandom % 4 == 0) ? 1 : 0,
                    ($urandom % 2 == 0) ? int'(2 + $urandom % 13) : 0);
         if ($urandom % 3 == 0) idle_cycles(1 + $urandom % 3);
      end
      idle_cycles(5);
      finish_run();
   end
endmodule